// File: doc/BRIEF.md
# SIMD Lane Saturation Unit

This execution unit clamps every lane of a 128-bit vector operand into a range chosen by an immediate carried in the instruction word. The unit decodes a 32-bit instruction from a family of eight saturate operations. From the word it takes the lane width (8, 16, 32 or 64 bits), the signedness and a bit-position immediate `k`. It then saturates all lanes in parallel and registers the result.

In signed mode each lane is forced into the two's-complement range from -(2^k) to 2^k - 1. In unsigned mode each lane is limited to 2^(k+1) - 1. The unit also returns the destination and source register indices taken from the word. An instruction word that matches none of the eight encodings raises a one-cycle unrecognised flag, and the unit does not update the result.

Top module: `lane_sat_unit`

## Requirements
- R1: The 128-bit source is split into 16, 8, 4 or 2 lanes of 8, 16, 32 or 64 bits. Lane i occupies bits [i*W+W-1 : i*W]. Each lane is saturated on its own, and the value of one lane never changes another lane's result.
- R2: In signed mode with immediate k, a lane read as a two's-complement number of its own width above 2^k - 1 becomes 2^k - 1. A lane below -(2^k) becomes -(2^k). A lane equal to -(2^k) is left unchanged.
- R3: In unsigned mode with immediate k, a lane above 2^(k+1) - 1 becomes 2^(k+1) - 1. With 64-bit lanes and k = 63 every value passes unchanged.
- R4: A lane that already lies inside the selected range is output bit-exact.
- R5: Bits [31:20] must be 0x732. Bits [19:18] are 01 for signed and 10 for unsigned. The lane width is selected by bits [17:13] = 00001 (8-bit, k in [12:10]), bits [17:14] = 0001 (16-bit, k in [13:10]), bits [17:15] = 001 (32-bit, k in [14:10]) or bits [17:16] = 01 (64-bit, k in [15:10]).
- R6: A valid word that matches none of the encodings in R5 sets `bad_op` high for exactly the next cycle. In that cycle `out_valid` stays low and `result` keeps its previous value.
- R7: A valid, recognised word gives `out_valid` high for exactly the cycle after it is sampled, with the saturated `result` in that same cycle. Every valid word loads `rd_idx` from bits [4:0] and `rs_idx` from bits [9:5], which appear one cycle later.
- R8: A synchronous active-high reset clears `out_valid`, `bad_op`, `result`, `rd_idx` and `rs_idx` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and source vector are present |
| insn | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector operand |
| out_valid | output | 1 | Result is valid this cycle |
| result | output | 128 | Registered saturated vector |
| rd_idx | output | 5 | Destination register index from the last valid word |
| rs_idx | output | 5 | Source register index from the last valid word |
| bad_op | output | 1 | Last valid word was not recognised |

## Verification
The bench builds the unit with its default 128-bit vector width, so all four lane counts are exercised at full size. Every immediate from 0 to its maximum is swept for each of the eight operations. This sweep reaches the k = 63 unsigned pass-through and the k = 0 signed range of {-1, 0}. Lanes hold zero, the most negative value, the most positive value, all ones, the exact signed lower bound, alternating extremes and random data. Malformed words are placed between good ones, so the held result and the one-cycle flag can be observed.

// File: rtl/lane_sat_pkg.sv
package lane_sat_pkg;

  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2,
    LW_64 = 2'd3
  } lane_w_e;

  typedef struct packed {
    logic       ok;
    logic       sgn;
    lane_w_e    lw;
    logic [5:0] imm;
  } sat_op_t;

  // x is the lane sign-extended to 64 bits; range is [-(2^k), 2^k - 1]
  function automatic logic [63:0] sat_signed(input logic [63:0] x, input logic [5:0] k);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    logic signed [63:0] sx;
    hi = $signed((64'd1 << k) - 64'd1);
    lo = ~hi;
    sx = $signed(x);
    if (sx > hi)      return hi;
    else if (sx < lo) return lo;
    else              return x;
  endfunction

  // x is the lane zero-extended to 64 bits; bound is 2^(k+1) - 1
  function automatic logic [63:0] sat_unsigned(input logic [63:0] x, input logic [5:0] k);
    logic [63:0] bnd;
    logic [6:0]  sh;
    sh  = {1'b0, k} + 7'd1;
    bnd = (k == 6'd63) ? {64{1'b1}} : ((64'd1 << sh) - 64'd1);
    return (x > bnd) ? bnd : x;
  endfunction

endpackage

// File: rtl/lane_sat_decode.sv
module lane_sat_decode
  import lane_sat_pkg::*;
#(
  parameter logic [11:0] OPC_MAJOR = 12'h732
) (
  input  logic [31:0] insn,
  output sat_op_t     op
);

  logic major_hit;
  logic mode_hit;

  assign major_hit = (insn[31:20] == OPC_MAJOR);
  assign mode_hit  = (insn[19:18] == 2'b01) || (insn[19:18] == 2'b10);

  always_comb begin
    op     = '0;
    op.lw  = LW_8;
    op.sgn = (insn[19:18] == 2'b01);
    if (major_hit && mode_hit) begin
      if (insn[17:13] == 5'b00001) begin
        op.ok  = 1'b1;
        op.lw  = LW_8;
        op.imm = {3'b000, insn[12:10]};
      end else if (insn[17:14] == 4'b0001) begin
        op.ok  = 1'b1;
        op.lw  = LW_16;
        op.imm = {2'b00, insn[13:10]};
      end else if (insn[17:15] == 3'b001) begin
        op.ok  = 1'b1;
        op.lw  = LW_32;
        op.imm = {1'b0, insn[14:10]};
      end else if (insn[17:16] == 2'b01) begin
        op.ok  = 1'b1;
        op.lw  = LW_64;
        op.imm = insn[15:10];
      end
    end
  end

endmodule

// File: rtl/lane_sat_lane.sv
module lane_sat_lane
  import lane_sat_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  logic [5:0]   imm,
  input  logic         sgn,
  output logic [W-1:0] dout,
  output logic         clipped
);

  logic [63:0] ext;
  logic [63:0] sat;

  always_comb begin
    ext     = sgn ? 64'($signed(din)) : 64'(din);
    sat     = sgn ? sat_signed(ext, imm) : sat_unsigned(ext, imm);
    dout    = sat[W-1:0];
    clipped = (sat != ext);
  end

  always_comb begin
    if (!$isunknown({din, imm, sgn})) begin
      if (clipped && sgn) begin
        AST_SIGN_KEPT: assert (dout[W-1] == din[W-1]); // R2
      end
      if (clipped && !sgn) begin
        AST_USAT_SHRINKS: assert (dout < din); // R3
      end
    end
  end

endmodule

// File: rtl/lane_sat_unit.sv
module lane_sat_unit
  import lane_sat_pkg::*;
#(
  parameter int          VEC_W     = 128,
  parameter logic [11:0] OPC_MAJOR = 12'h732
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [31:0]      insn,
  input  logic [VEC_W-1:0] src_vec,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic [4:0]       rd_idx,
  output logic [4:0]       rs_idx,
  output logic             bad_op
);

  localparam int N_WIDTHS = 4;
  localparam int MAX_LANES = VEC_W / 8;

  sat_op_t              op;
  logic [VEC_W-1:0]     res_w  [N_WIDTHS];
  logic [MAX_LANES-1:0] clip_w [N_WIDTHS];
  logic [VEC_W-1:0]     sel_res;
  logic [MAX_LANES-1:0] sel_clip;
  logic                 accept_ok;
  logic                 accept_bad;

  lane_sat_decode #(.OPC_MAJOR(OPC_MAJOR)) u_dec (
    .insn (insn),
    .op   (op)
  );

  for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
    localparam int LW = 8 << g;
    localparam int NL = VEC_W / LW;
    for (genvar i = 0; i < NL; i++) begin : g_lane
      lane_sat_lane #(.W(LW)) u_lane (
        .din     (src_vec[i*LW +: LW]),
        .imm     (op.imm),
        .sgn     (op.sgn),
        .dout    (res_w[g][i*LW +: LW]),
        .clipped (clip_w[g][i])
      );
    end
    for (genvar j = NL; j < MAX_LANES; j++) begin : g_pad
      assign clip_w[g][j] = 1'b0;
    end
  end

  assign sel_res    = res_w[op.lw];
  assign sel_clip   = clip_w[op.lw];
  assign accept_ok  = in_valid && op.ok;
  assign accept_bad = in_valid && !op.ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      bad_op    <= 1'b0;
      result    <= '0;
      rd_idx    <= '0;
      rs_idx    <= '0;
    end else begin
      out_valid <= accept_ok;
      bad_op    <= accept_bad;
      if (accept_ok) result <= sel_res;
      if (in_valid) begin
        rd_idx <= insn[4:0];
        rs_idx <= insn[9:5];
      end
    end
  end

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    accept_ok |=> (out_valid && !bad_op)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !bad_op)); // R7

  AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    accept_bad |=> (bad_op && !out_valid && $stable(result))); // R6

  AST_NOCLIP_PASS: assert property (@(posedge clk) disable iff (rst)
    (accept_ok && (sel_clip == '0)) |=> (result == $past(src_vec))); // R4

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (rd_idx == $past(insn[4:0]) && rs_idx == $past(insn[9:5]))); // R7

endmodule

// File: tb/lane_sat_unit_tb.sv
`timescale 1ns/1ps
module lane_sat_unit_tb;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [31:0]  insn;
  logic [127:0] src_vec;
  logic         out_valid;
  logic [127:0] result;
  logic [4:0]   rd_idx;
  logic [4:0]   rs_idx;
  logic         bad_op;

  int n_vec = 0;
  int n_bad = 0;
  logic [127:0] last_res = '0;

  always #4 clk = ~clk;

  lane_sat_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .src_vec(src_vec),
    .out_valid(out_valid), .result(result), .rd_idx(rd_idx), .rs_idx(rs_idx),
    .bad_op(bad_op)
  );

  function automatic logic [127:0] model(logic [127:0] v, bit sgn, int lw, int k);
    logic [127:0] r;
    logic [63:0]  u;
    logic [63:0]  bnd;
    longint       s;
    longint       hi;
    r = '0;
    for (int i = 0; i < 128 / lw; i++) begin
      u = '0;
      for (int b = 0; b < lw; b++) u[b] = v[i*lw + b];
      if (sgn) begin
        s  = longint'(u << (64 - lw)) >>> (64 - lw);
        hi = (longint'(1) << k) - 1;
        if (s > hi) s = hi;
        else if (s < -hi - 1) s = -hi - 1;
        u = 64'(s);
      end else begin
        bnd = (k >= 63) ? {64{1'b1}} : ((64'd1 << (k + 1)) - 64'd1);
        if (u > bnd) u = bnd;
      end
      for (int b = 0; b < lw; b++) r[i*lw + b] = u[b];
    end
    return r;
  endfunction

  function automatic logic [31:0] mk_insn(bit sgn, int wsel, int k, int rd, int rs);
    logic [31:0] w;
    logic [5:0]  kk;
    kk = k[5:0];
    w = '0;
    w[31:20] = 12'h732;
    w[19:18] = sgn ? 2'b01 : 2'b10;
    case (wsel)
      0: begin w[17:13] = 5'b00001; w[12:10] = kk[2:0]; end
      1: begin w[17:14] = 4'b0001;  w[13:10] = kk[3:0]; end
      2: begin w[17:15] = 3'b001;   w[14:10] = kk[4:0]; end
      default: begin w[17:16] = 2'b01; w[15:10] = kk; end
    endcase
    w[9:5] = rs[4:0];
    w[4:0] = rd[4:0];
    return w;
  endfunction

  function automatic logic [127:0] pattern(int kind, int lw, int k);
    logic [127:0] v;
    v = '0;
    for (int i = 0; i < 128 / lw; i++) begin
      for (int b = 0; b < lw; b++) begin
        case (kind)
          1: v[i*lw + b] = (b == lw - 1);
          2: v[i*lw + b] = (b != lw - 1);
          3: v[i*lw + b] = 1'b1;
          4: v[i*lw + b] = 1'($urandom);
          5: v[i*lw + b] = (i % 2 == 0) ? (b == lw - 1) : (b != lw - 1);
          6: v[i*lw + b] = (b >= k);
          default: v[i*lw + b] = 1'b0;
        endcase
      end
    end
    return v;
  endfunction

  task automatic apply_ok(string tag, bit sgn, int wsel, int k, logic [127:0] v);
    logic [127:0] exp;
    int rd;
    int rs;
    int lw;
    lw = 8 << wsel;
    rd = int'($urandom_range(31, 0));
    rs = int'($urandom_range(31, 0));
    exp = model(v, sgn, lw, k);
    @(negedge clk);
    in_valid = 1'b1;
    insn     = mk_insn(sgn, wsel, k, rd, rs);
    src_vec  = v;
    @(negedge clk);
    in_valid = 1'b0;
    n_vec++;
    if (out_valid !== 1'b1 || bad_op !== 1'b0 || result !== exp ||
        rd_idx !== 5'(rd) || rs_idx !== 5'(rs)) begin
      n_bad++;
      $display("FAIL %s R7 sgn=%0d lw=%0d k=%0d: got v=%0d bad=%0d res=%h rd=%0d rs=%0d exp v=1 bad=0 res=%h rd=%0d rs=%0d",
               tag, sgn, lw, k, out_valid, bad_op, result, rd_idx, rs_idx, exp, rd, rs);
    end
    last_res = exp;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || bad_op !== 1'b0) begin
      n_bad++;
      $display("FAIL R7 strobe width: got v=%0d bad=%0d exp v=0 bad=0", out_valid, bad_op);
    end
  endtask

  task automatic apply_bad(logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    insn     = w;
    src_vec  = pattern(4, 8, 0);
    @(negedge clk);
    in_valid = 1'b0;
    n_vec++;
    if (bad_op !== 1'b1 || out_valid !== 1'b0 || result !== last_res) begin
      n_bad++;
      $display("FAIL R6 word=%h: got bad=%0d v=%0d res=%h exp bad=1 v=0 res=%h",
               w, bad_op, out_valid, result, last_res);
    end
    @(negedge clk);
    n_vec++;
    if (bad_op !== 1'b0) begin
      n_bad++;
      $display("FAIL R6 flag width: got bad=%0d exp 0", bad_op);
    end
  endtask

  task automatic check_reset(string when);
    n_vec++;
    if (out_valid !== 1'b0 || bad_op !== 1'b0 || result !== '0 ||
        rd_idx !== '0 || rs_idx !== '0) begin
      n_bad++;
      $display("FAIL R8 %s: got v=%0d bad=%0d res=%h rd=%0d rs=%0d exp all zero",
               when, out_valid, bad_op, result, rd_idx, rs_idx);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; insn = '0; src_vec = '0;
    repeat (3) @(negedge clk);
    check_reset("after power-up");
    rst = 1'b0;

    // R1 R2 R3 R4 R5: every operation, every immediate, many lane patterns
    for (int s = 0; s < 2; s++) begin
      for (int wsel = 0; wsel < 4; wsel++) begin
        for (int k = 0; k < (8 << wsel); k++) begin
          apply_ok("R5 zero R4",         bit'(s), wsel, k, pattern(0, 8 << wsel, k));
          apply_ok("R2 R3 most negative", bit'(s), wsel, k, pattern(1, 8 << wsel, k));
          apply_ok("R2 R3 most positive", bit'(s), wsel, k, pattern(2, 8 << wsel, k));
          apply_ok("R3 all ones",        bit'(s), wsel, k, pattern(3, 8 << wsel, k));
          apply_ok("R1 random",          bit'(s), wsel, k, pattern(4, 8 << wsel, k));
          apply_ok("R1 alternating",     bit'(s), wsel, k, pattern(5, 8 << wsel, k));
          apply_ok("R2 lower bound",     bit'(s), wsel, k, pattern(6, 8 << wsel, k));
        end
      end
    end

    // R3 explicit: 64-bit unsigned with k=63 passes all-ones unchanged
    apply_ok("R3 k63 passthrough", 1'b0, 3, 63, {128{1'b1}});

    // R6: malformed words between good ones
    apply_bad({12'h733, 20'h48000});
    apply_ok("R6 refill", 1'b1, 1, 5, pattern(4, 16, 5));
    apply_bad({12'h732, 2'b00, 5'b00001, 13'h0});
    apply_bad({12'h732, 2'b11, 5'b00001, 13'h0});
    apply_bad({12'h732, 2'b01, 5'b00000, 13'h1FFF});
    apply_bad({12'h732, 2'b10, 5'b00000, 13'h0});

    // R8: reset mid-run clears everything
    apply_ok("R8 before reset", 1'b1, 0, 3, pattern(4, 8, 3));
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset("mid-run");
    rst = 1'b0;
    last_res = '0;
    apply_bad({12'h000, 20'h0});

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule